// File: doc/BRIEF.md
# Fractional Rate Oscillator for Serial Timing

This block turns a fast system clock into a slower rate for serial-port bit timing, using a phase accumulator rather than an integer reload counter. A programmable step is added to an ACC_W-bit phase register on every clock, modulo 2^ACC_W. The top bit of the phase register is the output square wave. A carry out of the addition raises a one-cycle rate tick, which a shifter can use as its bit enable. The average output frequency is f_clk × step / 2^ACC_W, with a resolution of f_clk / 2^ACC_W.

When the ratio 2^ACC_W / step is not an integer, the gaps between ticks alternate between the two integers on either side of that ratio. The error is corrected on every period and never builds up. The step value sits in its own register, so the clocked path holds a single adder. A new step is loaded by strobe and does not disturb the phase.

Top module: `frac_rate_nco`

## Requirements
- R1: On every clock edge the phase register adds the current step modulo 2^ACC_W. Over any run of exactly 2^ACC_W edges with a fixed step, the number of cycles with `rate_tick` high equals the step value.
- R2: `rate_square` is the most significant phase bit. For a step of at most 2^(ACC_W-1), it rises exactly step times in 2^ACC_W edges.
- R3: `rate_tick` is high for the cycle that follows each edge at which the addition carries out of the top bit, and low otherwise. Every falling edge of `rate_square` comes with a tick.
- R4: The distance in cycles between consecutive ticks is always floor(2^ACC_W/step) or ceil(2^ACC_W/step).
- R5: For a step of at most 2^(ACC_W-1), each high phase of `rate_square` lasts floor(2^(ACC_W-1)/step) or ceil(2^(ACC_W-1)/step) cycles.
- R6: `step_value` is captured at an edge where `step_load` is high. That edge still adds the old step, the new step is added from the next edge on, and the load never clears the phase.
- R7: A load on the same edge as a carry does not lose that carry: the tick still follows.
- R8: Synchronous reset sets the phase to zero and the step to INIT_STEP (default 0). `rate_tick` and `rate_square` are low in the cycle after reset.
- R9: With a step of zero, `rate_square` does not change and no tick appears.
- R10: ACC_W is a parameter, checked at elaboration to lie in 4..48. At ACC_W = 16, a step of 8520 gives exactly 8520 ticks in 65536 clocks, which is 13.000488 MHz from 100 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| step_load | input | 1 | Strobe that captures `step_value` |
| step_value | input | ACC_W | Phase step to capture |
| rate_square | output | 1 | Square output, the top phase bit |
| rate_tick | output | 1 | One-cycle pulse per phase wrap |

## Verification
A step reload and a phase wrap can fall on the same clock edge. The bench sets up this collision on purpose: it loads a step of 64 from a zero phase and strobes a new step of 96 on the fourth edge, where the phase wraps. It then checks that the tick still follows that edge and that the next ticks are spaced by the new step with the phase left intact. A second directed case loads at a known phase value and shows that the phase carries on from where it was instead of restarting.

// File: rtl/frac_nco_pkg.sv
package frac_nco_pkg;
   localparam int unsigned NCO_MIN_W = 4;
   localparam int unsigned NCO_MAX_W = 48;

   function automatic bit nco_width_ok(input int unsigned w);
      return (w >= NCO_MIN_W) && (w <= NCO_MAX_W);
   endfunction
endpackage

// File: rtl/nco_step_reg.sv
module nco_step_reg #(
   parameter int unsigned W         = 16,
   parameter longint unsigned INIT  = 0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load_i,
   input  logic [W-1:0] step_i,
   output logic [W-1:0] step_o
);
   localparam logic [W-1:0] INIT_V = W'(INIT);

   logic armed;

   always_ff @(posedge clk) begin
      if (rst) begin
         step_o <= INIT_V;
         armed  <= 1'b0;
      end else begin
         armed <= 1'b1;
         if (load_i) step_o <= step_i;
      end
   end

   // R6: a strobe captures the input; without a strobe the step holds
   assert_load_capture_R6: assert property (@(posedge clk) disable iff (rst)
      (armed && $past(load_i)) |-> (step_o == $past(step_i)));
   assert_step_holds_R6: assert property (@(posedge clk) disable iff (rst)
      (armed && !$past(load_i)) |-> $stable(step_o));
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] step_i,
   output logic [W-1:0] phase_o,
   output logic         carry_o
);
   logic [W:0] sum_w;
   logic       armed;

   assign sum_w = {1'b0, phase_o} + {1'b0, step_i};

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_o <= '0;
         carry_o <= 1'b0;
         armed   <= 1'b0;
      end else begin
         phase_o <= sum_w[W-1:0];
         carry_o <= sum_w[W];
         armed   <= 1'b1;
      end
   end

   // R3: a carry is flagged exactly when the phase moved backwards
   assert_carry_on_wrap_R3: assert property (@(posedge clk) disable iff (rst)
      armed |-> (carry_o == (phase_o < $past(phase_o))));
   // R9: a zero step freezes the phase and produces no carry
   assert_zero_step_idle_R9: assert property (@(posedge clk) disable iff (rst)
      (armed && ($past(step_i) == '0)) |-> ($stable(phase_o) && !carry_o));
   // R8: reset leaves a cleared phase and no carry
   assert_reset_clear_R8: assert property (@(posedge clk)
      rst |=> ((phase_o == '0) && !carry_o));
endmodule

// File: rtl/nco_out_stage.sv
module nco_out_stage #(
   parameter int unsigned W       = 16,
   parameter bit          RETIME  = 1'b0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] phase_i,
   input  logic         carry_i,
   output logic         square_o,
   output logic         tick_o
);
   localparam int unsigned MSB = W - 1;

   assign tick_o = carry_i;

   generate
      if (RETIME) begin : g_retimed
         logic sq_q;
         always_ff @(posedge clk) begin
            if (rst) sq_q <= 1'b0;
            else     sq_q <= phase_i[MSB];
         end
         assign square_o = sq_q;
      end else begin : g_direct
         assign square_o = phase_i[MSB];
      end
   endgenerate
endmodule

// File: rtl/frac_rate_nco.sv
module frac_rate_nco
   import frac_nco_pkg::*;
#(
   parameter int unsigned     ACC_W         = 16,
   parameter longint unsigned INIT_STEP     = 0,
   parameter bit              RETIME_SQUARE = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step_load,
   input  logic [ACC_W-1:0] step_value,
   output logic             rate_square,
   output logic             rate_tick
);
   localparam int unsigned TOP = ACC_W - 1;

   generate
      if (!nco_width_ok(ACC_W)) begin : g_bad_width
         $error("frac_rate_nco: ACC_W outside supported range");
      end
      if (INIT_STEP >= (64'd1 << ACC_W)) begin : g_bad_init
         $error("frac_rate_nco: INIT_STEP does not fit in ACC_W bits");
      end
   endgenerate

   logic [ACC_W-1:0] step_q;
   logic [ACC_W-1:0] phase;
   logic             carry;
   logic             armed;

   nco_step_reg #(.W(ACC_W), .INIT(INIT_STEP)) u_step (
      .clk    (clk),
      .rst    (rst),
      .load_i (step_load),
      .step_i (step_value),
      .step_o (step_q)
   );

   nco_phase_acc #(.W(ACC_W)) u_acc (
      .clk     (clk),
      .rst     (rst),
      .step_i  (step_q),
      .phase_o (phase),
      .carry_o (carry)
   );

   nco_out_stage #(.W(ACC_W), .RETIME(RETIME_SQUARE)) u_out (
      .clk      (clk),
      .rst      (rst),
      .phase_i  (phase),
      .carry_i  (carry),
      .square_o (rate_square),
      .tick_o   (rate_tick)
   );

   always_ff @(posedge clk) begin
      if (rst) armed <= 1'b0;
      else     armed <= 1'b1;
   end

   // R3: the top phase bit can only drop through a wrap
   assert_fall_has_tick_R3: assert property (@(posedge clk) disable iff (rst)
      (armed && $past(phase[TOP]) && !phase[TOP]) |-> rate_tick);
   // R9: a zero step keeps the top bit fixed
   assert_zero_step_static_R9: assert property (@(posedge clk) disable iff (rst)
      (armed && ($past(step_q) == '0)) |-> $stable(phase[TOP]));
endmodule

// File: tb/tb_frac_rate_nco.sv
`timescale 1ns/1ps
module tb_frac_rate_nco;
   localparam int unsigned N   = 8;
   localparam int unsigned NW  = 16;
   localparam int          FULL = 1 << N;
   localparam int          HALF = 1 << (N - 1);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          step_load = 1'b0;
   logic [N-1:0]  step_value = '0;
   logic          rate_square, rate_tick;
   logic          wide_load = 1'b0;
   logic [NW-1:0] wide_value = '0;
   logic          wide_square, wide_tick;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;

   always #2.5 clk = ~clk;

   frac_rate_nco #(.ACC_W(N)) dut (
      .clk(clk), .rst(rst), .step_load(step_load), .step_value(step_value),
      .rate_square(rate_square), .rate_tick(rate_tick));

   frac_rate_nco #(.ACC_W(NW)) dut_wide (
      .clk(clk), .rst(rst), .step_load(wide_load), .step_value(wide_value),
      .rate_square(wide_square), .rate_tick(wide_tick));

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic next_cycle();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      step_load = 1'b0;
      wide_load = 1'b0;
      repeat (3) next_cycle();
      check(rate_tick == 1'b0, "R8 tick in reset", rate_tick, 0);
      check(rate_square == 1'b0, "R8 square in reset", rate_square, 0);
      rst = 1'b0;
   endtask

   // load step v, then watch exactly FULL edges using it
   task automatic measure(input int v);
      int ticks = 0, rises = 0, changes = 0;
      int last_t = -1, rise_t = -1;
      int lo, hi, hlo, hhi;
      bit prev_sq;
      step_load  = 1'b1;
      step_value = N'(v);
      next_cycle();
      step_load = 1'b0;
      prev_sq = rate_square;
      if (v != 0) begin
         lo  = FULL / v;  hi  = lo  + ((FULL % v) != 0 ? 1 : 0);
         hlo = HALF / v;  hhi = hlo + ((HALF % v) != 0 ? 1 : 0);
      end else begin
         lo = 0; hi = 0; hlo = 0; hhi = 0;
      end
      for (int i = 1; i <= FULL; i++) begin
         next_cycle();
         if (rate_tick) begin
            ticks++;
            if (last_t >= 0)
               check(((i - last_t) == lo) || ((i - last_t) == hi),
                     "R4 tick spacing", i - last_t, lo);
            last_t = i;
         end
         if (rate_square != prev_sq) changes++;
         if (rate_square && !prev_sq) begin
            rises++;
            rise_t = i;
         end
         if (!rate_square && prev_sq) begin
            check(rate_tick == 1'b1, "R3 fall without tick", rate_tick, 1);
            if (rise_t >= 0 && v <= HALF)
               check(((i - rise_t) == hlo) || ((i - rise_t) == hhi),
                     "R5 high time", i - rise_t, hlo);
         end
         prev_sq = rate_square;
      end
      check(ticks == v, "R1 ticks per window", ticks, v);
      if (v <= HALF) check(rises == v, "R2 square rises", rises, v);
      if (v == 0) begin
         check(changes == 0, "R9 square static", changes, 0);
         check(ticks == 0, "R9 no ticks", ticks, 0);
      end
   endtask

   initial begin
      do_reset();
      // R8: reset step is zero, so nothing moves without a load
      for (int i = 0; i < 20; i++) begin
         next_cycle();
         if (i == 19) begin
            check(rate_tick == 1'b0, "R8 idle tick after reset", rate_tick, 0);
            check(rate_square == 1'b0, "R8 idle square after reset", rate_square, 0);
         end
      end

      // R6: load step 1, advance phase to 100, then load 200
      step_load = 1'b1; step_value = N'(1);
      next_cycle();
      step_load = 1'b0;
      repeat (100) next_cycle();
      check(rate_square == 1'b0, "R6 phase below half", rate_square, 0);
      step_load = 1'b1; step_value = N'(200);
      next_cycle();
      step_load = 1'b0;
      check(rate_tick == 1'b0, "R6 old step on load edge", rate_tick, 0);
      next_cycle();
      check(rate_tick == 1'b1, "R6 phase kept, 101+200 wraps", rate_tick, 1);
      check(rate_square == 1'b0, "R6 phase 45 square low", rate_square, 0);
      next_cycle();
      check(rate_tick == 1'b0, "R6 phase 245 no wrap", rate_tick, 0);
      check(rate_square == 1'b1, "R6 phase 245 square high", rate_square, 1);

      // R7: load collides with a wrap
      do_reset();
      step_load = 1'b1; step_value = N'(64);
      next_cycle();
      step_load = 1'b0;
      repeat (3) next_cycle();
      step_load = 1'b1; step_value = N'(96);
      next_cycle();
      step_load = 1'b0;
      check(rate_tick == 1'b1, "R7 tick on load edge", rate_tick, 1);
      next_cycle();
      check(rate_tick == 1'b0, "R7 phase 96", rate_tick, 0);
      next_cycle();
      check(rate_tick == 1'b0, "R7 phase 192", rate_tick, 0);
      next_cycle();
      check(rate_tick == 1'b1, "R7 phase 32 after wrap", rate_tick, 1);

      // R1..R5, R9: sweep every step value
      for (int v = 0; v < FULL; v++) measure(v);

      // R10: wide instance, 8520 over 65536 clocks
      wide_load = 1'b1; wide_value = NW'(8520);
      next_cycle();
      wide_load = 1'b0;
      begin
         int wt = 0;
         for (int i = 0; i < (1 << NW); i++) begin
            next_cycle();
            if (wide_tick) wt++;
         end
         check(wt == 8520, "R10 wide tick count", wt, 8520);
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 195000, 0);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule